// File: doc/BRIEF.md
# TMDS Transmitter PHY Bring-Up Sequencer

This block brings a TMDS transmitter PHY from a powered-down state to a locked, transmitting state for a given pixel clock, with no processor involved. After a start pulse it powers the PHY down and resets it. It then programs nine 16-bit PHY registers through a small internal management-bus master, powers the transmitter back up in a fixed order, and waits for the PLL to report lock. The whole pass runs twice. Success is reported only when the second pass locks.

Several register words depend on the pixel clock, which arrives in kHz. The block sorts the clock into bands and picks a charge-pump/gain pair, a current-control word, a symbol-control option and a voltage level. A single prescaler turns the system clock into a millisecond tick. Every wait is counted in whole milliseconds of that tick: the completion wait on each register write, and the PLL-lock wait.

Top module: `tmds_phy_bringup`

## Requirements
- R1: Each register write is one cycle of `mb_clr`, then in the next cycle one cycle of `mb_wr`. Address and data are valid with the strobe and stay unchanged until the write completes.
- R2: A write completes when `mb_done` or `mb_err` is seen. If neither arrives within WR_TIMEOUT_MS milliseconds, the write completes anyway and the sequence goes on without failing.
- R3: At the start of each pass, `tx_pwr_on`, `phy_pwr_en` and `tmds_en` go low and `pddq` goes high. `phy_rst` pulses high for one cycle and `aux_rst` is set. All of this happens before the first write of that pass.
- R4: Each pass writes, in this order: 0x06 charge pump, 0x15 gain, 0x10 current, 0x13 PLL bypass (0x0000), 0x17 feedback mode (0x0008), 0x19 termination (0x0004), 0x05 clock calibration (0x8000), 0x09 symbol control, 0x0E voltage level. The charge-pump word is 0x0100+b and the gain word is 0x0200+b, where the band b is 0 up to 45250 kHz, 1 up to 92500, 2 up to 185000, and 3 above that.
- R5: The current word is 0x091C up to 58400 kHz, 0x06DC up to 74250, 0x091C up to 118800, and 0x06DC up to 216000.
- R6: Above 148500 kHz the symbol-control word is 0x800A and the voltage word is 0x0129 (level 9 in bits 9:5 and 4:0). Otherwise they are 0x8009 and 0x01AD (level 13).
- R7: After the last write, `phy_pwr_en` rises, `tmds_en` is driven low and then high, `tx_pwr_on` rises, and `pddq` falls last.
- R8: If `pll_lock` stays low for LOCK_TIMEOUT_MS milliseconds after `pddq` falls, `failure` rises exactly LOCK_TIMEOUT_MS*TICK_DIV cycles after the fall. No further writes follow.
- R9: The pass runs PASSES times (default 2), giving 18 writes in total. `success` rises only once the last pass has locked.
- R10: A start with a pixel clock above 216000 kHz raises `failure` in the next cycle. `busy` stays low and no write is issued.
- R11: `busy` is high from the cycle after an accepted start until a verdict. `success` and `failure` are never high together and never high while `busy` is high. A start while busy is ignored.
- R12: After reset, `busy`, `success`, `failure`, `mb_wr`, `mb_clr`, `tx_pwr_on`, `phy_pwr_en` and `tmds_en` are low, and `pddq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin bring-up (pulse) |
| pclk_khz | input | PCLK_W | Pixel clock in kHz, latched at start |
| mb_done | input | 1 | Management write completed flag |
| mb_err | input | 1 | Management write error flag |
| pll_lock | input | 1 | PHY PLL lock status |
| mb_clr | output | 1 | Clear done/error flags |
| mb_wr | output | 1 | Write command strobe |
| mb_addr | output | 8 | PHY register address |
| mb_data_hi | output | 8 | Write data, upper byte |
| mb_data_lo | output | 8 | Write data, lower byte |
| phy_pwr_en | output | 1 | PHY power enable |
| tmds_en | output | 1 | TMDS output enable |
| tx_pwr_on | output | 1 | Transmitter power on |
| pddq | output | 1 | PHY power-down request |
| phy_rst | output | 1 | PHY reset pulse |
| aux_rst | output | 1 | Auxiliary PHY reset |
| busy | output | 1 | Sequence in progress |
| success | output | 1 | Both passes locked |
| failure | output | 1 | Lock timeout or unsupported clock |

## Verification
The bench builds the block with TICK_DIV=10, WR_TIMEOUT_MS=3 and LOCK_TIMEOUT_MS=4. A millisecond is then ten cycles, so a write timeout costs 30 cycles and a lock timeout 40. With these values a run in which every write is left unanswered, and a run that never locks, both finish in a few hundred cycles. The exact timeout cycle and the minimum spacing between strobes can therefore be checked directly, and the same tests also sweep every band edge of the pixel clock.

// File: rtl/tmds_phy_seq_pkg.sv
package tmds_phy_seq_pkg;

    localparam int NUM_WRITES = 9;

    localparam int unsigned BAND0_MAX_KHZ = 45250;
    localparam int unsigned BAND1_MAX_KHZ = 92500;
    localparam int unsigned BAND2_MAX_KHZ = 185000;
    localparam int unsigned CURR_A_MAX_KHZ = 58400;
    localparam int unsigned CURR_B_MAX_KHZ = 74250;
    localparam int unsigned CURR_C_MAX_KHZ = 118800;
    localparam int unsigned RATE_MAX_KHZ = 216000;
    localparam int unsigned FAST_MIN_KHZ = 148500;

    localparam logic [7:0] RA_CPUMP = 8'h06;
    localparam logic [7:0] RA_GAIN  = 8'h15;
    localparam logic [7:0] RA_CURR  = 8'h10;
    localparam logic [7:0] RA_PLLBY = 8'h13;
    localparam logic [7:0] RA_FBMODE = 8'h17;
    localparam logic [7:0] RA_TERM  = 8'h19;
    localparam logic [7:0] RA_CKCAL = 8'h05;
    localparam logic [7:0] RA_SYMCTL = 8'h09;
    localparam logic [7:0] RA_VLEVEL = 8'h0E;

    typedef struct packed {
        logic [1:0] band;
        logic       curr_alt;
        logic       fast;
        logic       unsupported;
    } rate_cfg_t;

    typedef struct packed {
        logic [7:0]  addr;
        logic [15:0] data;
    } mgmt_word_t;

    typedef enum logic [1:0] {E_IDLE, E_CLR, E_STROBE, E_WAIT} eng_state_t;

    typedef enum logic [3:0] {
        S_IDLE, S_PREP, S_WR_GO, S_WR_WAIT, S_PWR, S_TMDS_OFF,
        S_TMDS_ON, S_TX_ON, S_PDDQ_OFF, S_LOCK
    } seq_state_t;

    function automatic rate_cfg_t classify_rate(input int unsigned khz);
        rate_cfg_t c;
        if (khz <= BAND0_MAX_KHZ)      c.band = 2'd0;
        else if (khz <= BAND1_MAX_KHZ) c.band = 2'd1;
        else if (khz <= BAND2_MAX_KHZ) c.band = 2'd2;
        else                           c.band = 2'd3;
        c.curr_alt = ((khz > CURR_A_MAX_KHZ) && (khz <= CURR_B_MAX_KHZ)) ||
                     (khz > CURR_C_MAX_KHZ);
        c.fast        = khz > FAST_MIN_KHZ;
        c.unsupported = khz > RATE_MAX_KHZ;
        return c;
    endfunction

    function automatic mgmt_word_t step_word(input logic [3:0] idx, input rate_cfg_t c);
        mgmt_word_t w;
        logic [4:0] lvl;
        lvl = c.fast ? 5'd9 : 5'd13;
        case (idx)
            4'd0:    w = '{RA_CPUMP,  16'h0100 | {14'd0, c.band}};
            4'd1:    w = '{RA_GAIN,   16'h0200 | {14'd0, c.band}};
            4'd2:    w = '{RA_CURR,   c.curr_alt ? 16'h06DC : 16'h091C};
            4'd3:    w = '{RA_PLLBY,  16'h0000};
            4'd4:    w = '{RA_FBMODE, 16'h0008};
            4'd5:    w = '{RA_TERM,   16'h0004};
            4'd6:    w = '{RA_CKCAL,  16'h8000};
            4'd7:    w = '{RA_SYMCTL, c.fast ? 16'h800A : 16'h8009};
            default: w = '{RA_VLEVEL, {6'd0, lvl, lvl}};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ms_ticker.sv
module ms_ticker #(
    parameter int TICK_DIV = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mgmt_write_engine.sv
module mgmt_write_engine
    import tmds_phy_seq_pkg::*;
#(
    parameter int TMO_MS = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  mgmt_word_t word_in,
    input  logic       tick,
    input  logic       done_in,
    input  logic       err_in,
    output logic       mb_clr,
    output logic       mb_wr,
    output mgmt_word_t word_out,
    output logic       tick_clr,
    output logic       ack
);
    localparam int CW = $clog2(TMO_MS + 1);

    eng_state_t    st;
    logic [CW-1:0] cnt;

    assign mb_clr   = (st == E_CLR);
    assign mb_wr    = (st == E_STROBE);
    assign tick_clr = (st == E_STROBE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= E_IDLE;
            word_out <= '0;
            cnt      <= '0;
            ack      <= 1'b0;
        end else begin
            ack <= 1'b0;
            case (st)
                E_IDLE: if (go) begin
                    word_out <= word_in;
                    st       <= E_CLR;
                end
                E_CLR:    st <= E_STROBE;
                E_STROBE: begin
                    cnt <= '0;
                    st  <= E_WAIT;
                end
                default: begin
                    if (done_in || err_in) begin
                        ack <= 1'b1;
                        st  <= E_IDLE;
                    end else if (tick) begin
                        if (cnt == CW'(TMO_MS - 1)) begin
                            ack <= 1'b1;
                            st  <= E_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/tmds_phy_bringup.sv
module tmds_phy_bringup
    import tmds_phy_seq_pkg::*;
#(
    parameter int PCLK_W          = 20,
    parameter int TICK_DIV        = 100000,
    parameter int WR_TIMEOUT_MS   = 1000,
    parameter int LOCK_TIMEOUT_MS = 4,
    parameter int PASSES          = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PCLK_W-1:0] pclk_khz,
    input  logic              mb_done,
    input  logic              mb_err,
    input  logic              pll_lock,
    output logic              mb_clr,
    output logic              mb_wr,
    output logic [7:0]        mb_addr,
    output logic [7:0]        mb_data_hi,
    output logic [7:0]        mb_data_lo,
    output logic              phy_pwr_en,
    output logic              tmds_en,
    output logic              tx_pwr_on,
    output logic              pddq,
    output logic              phy_rst,
    output logic              aux_rst,
    output logic              busy,
    output logic              success,
    output logic              failure
);
    localparam int LW = $clog2(LOCK_TIMEOUT_MS + 1);
    localparam int PW = $clog2(PASSES + 1);

    seq_state_t    state;
    rate_cfg_t     cfg;
    rate_cfg_t     cfg_next;
    logic [3:0]    widx;
    logic [LW-1:0] lcnt;
    logic [PW-1:0] pass;
    logic          tick;
    logic          eng_tick_clr;
    logic          wr_ack;
    mgmt_word_t    cur_word;
    mgmt_word_t    bus_word;

    assign cfg_next = classify_rate(32'(pclk_khz));
    assign cur_word = step_word(widx, cfg);

    ms_ticker #(.TICK_DIV(TICK_DIV)) ticker_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (eng_tick_clr || (state == S_PDDQ_OFF)),
        .tick (tick)
    );

    mgmt_write_engine #(.TMO_MS(WR_TIMEOUT_MS)) engine_i (
        .clk      (clk),
        .rst      (rst),
        .go       (state == S_WR_GO),
        .word_in  (cur_word),
        .tick     (tick),
        .done_in  (mb_done),
        .err_in   (mb_err),
        .mb_clr   (mb_clr),
        .mb_wr    (mb_wr),
        .word_out (bus_word),
        .tick_clr (eng_tick_clr),
        .ack      (wr_ack)
    );

    assign mb_addr    = bus_word.addr;
    assign mb_data_hi = bus_word.data[15:8];
    assign mb_data_lo = bus_word.data[7:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            cfg        <= '0;
            widx       <= '0;
            lcnt       <= '0;
            pass       <= '0;
            phy_pwr_en <= 1'b0;
            tmds_en    <= 1'b0;
            tx_pwr_on  <= 1'b0;
            pddq       <= 1'b1;
            phy_rst    <= 1'b0;
            aux_rst    <= 1'b0;
            busy       <= 1'b0;
            success    <= 1'b0;
            failure    <= 1'b0;
        end else begin
            phy_rst <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    success <= 1'b0;
                    failure <= 1'b0;
                    if (cfg_next.unsupported) begin
                        failure <= 1'b1;
                    end else begin
                        busy  <= 1'b1;
                        cfg   <= cfg_next;
                        pass  <= '0;
                        state <= S_PREP;
                    end
                end
                S_PREP: begin
                    phy_pwr_en <= 1'b0;
                    tmds_en    <= 1'b0;
                    tx_pwr_on  <= 1'b0;
                    pddq       <= 1'b1;
                    phy_rst    <= 1'b1;
                    aux_rst    <= 1'b1;
                    widx       <= '0;
                    state      <= S_WR_GO;
                end
                S_WR_GO: state <= S_WR_WAIT;
                S_WR_WAIT: if (wr_ack) begin
                    if (widx == 4'(NUM_WRITES - 1)) begin
                        state <= S_PWR;
                    end else begin
                        widx  <= widx + 1'b1;
                        state <= S_WR_GO;
                    end
                end
                S_PWR: begin
                    phy_pwr_en <= 1'b1;
                    state      <= S_TMDS_OFF;
                end
                S_TMDS_OFF: begin
                    tmds_en <= 1'b0;
                    state   <= S_TMDS_ON;
                end
                S_TMDS_ON: begin
                    tmds_en <= 1'b1;
                    state   <= S_TX_ON;
                end
                S_TX_ON: begin
                    tx_pwr_on <= 1'b1;
                    state     <= S_PDDQ_OFF;
                end
                S_PDDQ_OFF: begin
                    pddq  <= 1'b0;
                    lcnt  <= '0;
                    state <= S_LOCK;
                end
                S_LOCK: begin
                    if (pll_lock) begin
                        if (pass == PW'(PASSES - 1)) begin
                            success <= 1'b1;
                            busy    <= 1'b0;
                            state   <= S_IDLE;
                        end else begin
                            pass  <= pass + 1'b1;
                            state <= S_PREP;
                        end
                    end else if (tick) begin
                        if (lcnt == LW'(LOCK_TIMEOUT_MS - 1)) begin
                            failure <= 1'b1;
                            busy    <= 1'b0;
                            state   <= S_IDLE;
                        end else begin
                            lcnt <= lcnt + 1'b1;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tmds_phy_bringup_chk.sv
module tmds_phy_bringup_chk (
    input logic clk,
    input logic rst,
    input logic mb_clr,
    input logic mb_wr,
    input logic tx_pwr_on,
    input logic pddq,
    input logic busy,
    input logic success,
    input logic failure
);
    AST_CLR_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        mb_wr |-> $past(mb_clr)); // R1
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mb_wr |=> !mb_wr); // R1
    AST_WRITE_POWERED_DOWN: assert property (@(posedge clk) disable iff (rst)
        mb_wr |-> (pddq && !tx_pwr_on)); // R3
    AST_PDDQ_RELEASE_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(pddq) |-> tx_pwr_on); // R7
    AST_BUSY_NO_VERDICT: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!success && !failure)); // R11
    AST_SINGLE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        !(success && failure)); // R11
endmodule

bind tmds_phy_bringup tmds_phy_bringup_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .mb_clr    (mb_clr),
    .mb_wr     (mb_wr),
    .tx_pwr_on (tx_pwr_on),
    .pddq      (pddq),
    .busy      (busy),
    .success   (success),
    .failure   (failure)
);

// File: tb/tmds_phy_bringup_tb_top.sv
module tmds_phy_bringup_tb_top;
    localparam int DIV     = 10;
    localparam int WR_TO   = 3;
    localparam int LOCK_TO = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [19:0] pclk_khz = '0;
    logic        mb_done = 1'b0;
    logic        mb_err = 1'b0;
    logic        pll_lock = 1'b0;
    logic        mb_clr, mb_wr, phy_pwr_en, tmds_en, tx_pwr_on, pddq;
    logic        phy_rst, aux_rst, busy, success, failure;
    logic [7:0]  mb_addr, mb_data_hi, mb_data_lo;

    int checks = 0;
    int errors = 0;

    int resp_mode = 0;
    bit lock_en = 1'b1;
    int n_wr = 0;
    logic [7:0]  log_addr [32];
    logic [15:0] log_data [32];
    int bad_prep = 0;
    int bad_order = 0;
    int rst_pulses = 0;
    int cyc = 0;
    int last_wr_cyc = 0;
    int min_gap = 1000000;
    int pddq_fall_cyc = 0;
    int fail_cyc = 0;

    always #5 clk = ~clk;

    tmds_phy_bringup #(
        .PCLK_W(20), .TICK_DIV(DIV), .WR_TIMEOUT_MS(WR_TO),
        .LOCK_TIMEOUT_MS(LOCK_TO), .PASSES(2)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .pclk_khz(pclk_khz),
        .mb_done(mb_done), .mb_err(mb_err), .pll_lock(pll_lock),
        .mb_clr(mb_clr), .mb_wr(mb_wr), .mb_addr(mb_addr),
        .mb_data_hi(mb_data_hi), .mb_data_lo(mb_data_lo),
        .phy_pwr_en(phy_pwr_en), .tmds_en(tmds_en), .tx_pwr_on(tx_pwr_on),
        .pddq(pddq), .phy_rst(phy_rst), .aux_rst(aux_rst),
        .busy(busy), .success(success), .failure(failure)
    );

    // Bus responder and observers, all acting at the falling edge
    initial begin
        int  delay;
        logic prev_pddq;
        logic prev_fail;
        delay = 0;
        prev_pddq = 1'b1;
        prev_fail = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (mb_clr) begin
                mb_done = 1'b0;
                mb_err  = 1'b0;
                delay   = 0;
            end
            if (mb_wr) begin
                if (n_wr < 32) begin
                    log_addr[n_wr] = mb_addr;
                    log_data[n_wr] = {mb_data_hi, mb_data_lo};
                end
                n_wr++;
                if (n_wr > 1 && (cyc - last_wr_cyc) < min_gap) min_gap = cyc - last_wr_cyc;
                last_wr_cyc = cyc;
                if (!pddq || tx_pwr_on || phy_pwr_en || tmds_en || !aux_rst) bad_prep++;
                if (resp_mode != 2) delay = 2;
            end
            if (delay > 0) begin
                delay--;
                if (delay == 0) begin
                    if (resp_mode == 1) mb_err = 1'b1;
                    else mb_done = 1'b1;
                end
            end
            if (phy_rst) rst_pulses++;
            if (prev_pddq && !pddq) begin
                pddq_fall_cyc = cyc;
                if (!(phy_pwr_en && tmds_en && tx_pwr_on)) bad_order++;
            end
            if (!prev_fail && failure) fail_cyc = cyc;
            prev_pddq = pddq;
            prev_fail = failure;
            pll_lock = lock_en && !pddq;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_word(input int idx, input int khz);
        int band;
        int lvl;
        logic [15:0] cur;
        bit fast;
        band = (khz <= 45250) ? 0 : (khz <= 92500) ? 1 : (khz <= 185000) ? 2 : 3;
        cur  = (khz <= 58400) ? 16'h091C : (khz <= 74250) ? 16'h06DC :
               (khz <= 118800) ? 16'h091C : 16'h06DC;
        fast = khz > 148500;
        lvl  = fast ? 9 : 13;
        case (idx)
            0: return {8'h06, 16'(256 + band)};
            1: return {8'h15, 16'(512 + band)};
            2: return {8'h10, cur};
            3: return {8'h13, 16'h0000};
            4: return {8'h17, 16'h0008};
            5: return {8'h19, 16'h0004};
            6: return {8'h05, 16'h8000};
            7: return {8'h09, fast ? 16'h800A : 16'h8009};
            default: return {8'h0E, 16'((lvl << 5) | lvl)};
        endcase
    endfunction

    task automatic clear_logs();
        n_wr = 0;
        bad_prep = 0;
        bad_order = 0;
        rst_pulses = 0;
        min_gap = 1000000;
        fail_cyc = 0;
        pddq_fall_cyc = 0;
    endtask

    task automatic launch(input int khz);
        int guard;
        pclk_khz = 20'(khz);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(guard < 5000, "R11 run completes", guard, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_writes(input int khz, input string req);
        int bad;
        int first_bad;
        bad = 0;
        first_bad = -1;
        check(n_wr == 18, "R9 write count", n_wr, 18);
        for (int i = 0; i < 18 && i < n_wr; i++) begin
            if ({log_addr[i], log_data[i]} !== exp_word(i % 9, khz)) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        end
        if (first_bad >= 0)
            check(1'b0, req, int'({log_addr[first_bad], log_data[first_bad]}),
                  int'(exp_word(first_bad % 9, khz)));
        else
            check(1'b1, req, 0, 0);
    endtask

    task automatic t_reset();
        check(!busy && !success && !failure, "R12 verdict outputs", {busy, success, failure}, 0);
        check(!mb_wr && !mb_clr, "R12 bus idle", {mb_wr, mb_clr}, 0);
        check(pddq && !tx_pwr_on && !phy_pwr_en && !tmds_en, "R12 power bits",
              {pddq, tx_pwr_on, phy_pwr_en, tmds_en}, 4'b1000);
    endtask

    task automatic t_normal(input int khz);
        clear_logs();
        resp_mode = 0;
        lock_en = 1'b1;
        pclk_khz = 20'(khz);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R11 busy after start", busy, 1);
        launch_wait();
        check(success && !failure, "R9 success after two passes", {success, failure}, 2'b10);
        check_writes(khz, "R4 R5 R6 write word");
        check(bad_prep == 0 && rst_pulses == 2, "R3 pre-program state", bad_prep * 16 + rst_pulses, 2);
        check(bad_order == 0, "R7 power-up order", bad_order, 0);
        check(phy_pwr_en && tmds_en && tx_pwr_on && !pddq, "R7 final power bits",
              {phy_pwr_en, tmds_en, tx_pwr_on, pddq}, 4'b1110);
    endtask

    task automatic launch_wait();
        int guard;
        guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(guard < 5000, "R11 run completes", guard, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_unsupported();
        clear_logs();
        pclk_khz = 20'd216001;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(failure && !busy && !success, "R10 immediate failure", {failure, busy, success}, 3'b100);
        repeat (20) @(negedge clk);
        check(n_wr == 0, "R10 no writes", n_wr, 0);
    endtask

    task automatic t_error_resp();
        clear_logs();
        resp_mode = 1;
        launch(100000);
        check(success, "R2 error flag completes write", success, 1);
        check_writes(100000, "R2 writes under error response");
        resp_mode = 0;
    endtask

    task automatic t_write_timeout();
        clear_logs();
        resp_mode = 2;
        launch(30000);
        check(success, "R2 timeout does not abort", success, 1);
        check(n_wr == 18, "R2 all writes issued", n_wr, 18);
        check(min_gap >= WR_TO * DIV, "R2 timeout spacing", min_gap, WR_TO * DIV);
        resp_mode = 0;
    endtask

    task automatic t_lock_fail();
        clear_logs();
        lock_en = 1'b0;
        launch(74250);
        check(failure && !success, "R8 lock timeout failure", {failure, success}, 2'b10);
        check(n_wr == 9, "R8 no second pass", n_wr, 9);
        check((fail_cyc - pddq_fall_cyc) == LOCK_TO * DIV, "R8 timeout cycle",
              fail_cyc - pddq_fall_cyc, LOCK_TO * DIV);
        lock_en = 1'b1;
    endtask

    task automatic t_start_ignored();
        clear_logs();
        pclk_khz = 20'd50000;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        pclk_khz = 20'd200000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        launch_wait();
        check(success, "R11 busy start ignored verdict", success, 1);
        check_writes(50000, "R11 busy start ignored words");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normal(25000);
        t_normal(45250);
        t_normal(45251);
        t_normal(58400);
        t_normal(58401);
        t_normal(74251);
        t_normal(92501);
        t_normal(118800);
        t_normal(118801);
        t_normal(148500);
        t_normal(148501);
        t_normal(185001);
        t_normal(216000);
        t_unsupported();
        t_error_resp();
        t_write_timeout();
        t_lock_fail();
        t_start_ignored();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule